// File: doc/BRIEF.md
# Packed Byte Saturating Add Unit

This unit recognises and executes one instruction: a packed unsigned add that treats each 32-bit operand as four independent bytes. Each byte sum is clamped at 255 rather than wrapping. The instruction word can arrive in either of two 32-bit layouts, chosen by a select input. The first layout is conditional and is gated by the current NZCV flags. The second layout always executes.

The two source values come in as plain inputs from a register read port. The unit reports five things:
- whether the word matched the instruction;
- the three register indices it carries;
- whether the write should happen;
- whether any index named register 15;
- the packed result.

Everything is captured in one output register stage. A valid bit follows the input valid bit one cycle later. The output stage is a two-state machine:
- **OS_EMPTY** means no result is presented.
- **OS_FULL** means a result is presented.

It has four transitions:
- **T_LOAD** goes from OS_EMPTY to OS_FULL when an input is valid.
- **T_STREAM** stays in OS_FULL on a further valid input.
- **T_DRAIN** goes from OS_FULL to OS_EMPTY when no input is valid.
- **T_REST** stays in OS_EMPTY while the input stays idle.

Reset forces OS_EMPTY.

Top module: `pbsat_add_unit`

## Requirements
- R1: Each operand is split into four byte lanes at bits [7:0], [15:8], [23:16] and [31:24]. Each lane is added as an unsigned value, and no carry passes from one lane into the next.
- R2: When a lane's 9-bit sum is 256 or more, the lane output is 0xFF. Otherwise the lane output is the low 8 bits of the sum.
- R3: With `enc_sel`=0, the word matches only when bits [27:20]=0x66, [11:8]=0xF and [7:4]=0x9. In this layout Rn is [19:16], Rd is [15:12], Rm is [3:0] and the condition is [31:28].
- R4: With `enc_sel`=1, the word matches only when bits [31:20]=0xFA8, [15:12]=0xF and [7:4]=0x5. In this layout Rn is [19:16], Rd is [11:8] and Rm is [3:0].
- R5: For `enc_sel`=0, `wr_en` is high only when the condition passes. The flags are N=`flags[3]`, Z=`flags[2]`, C=`flags[1]` and V=`flags[0]`. The condition codes are:

  | Code | Passes when |
  |---|---|
  | 0 | Z |
  | 1 | !Z |
  | 2 | C |
  | 3 | !C |
  | 4 | N |
  | 5 | !N |
  | 6 | V |
  | 7 | !V |
  | 8 | C&!Z |
  | 9 | !C\|Z |
  | 10 | N==V |
  | 11 | N!=V |
  | 12 | !Z&(N==V) |
  | 13 | Z\|(N!=V) |
  | 14 | always |

- R6: For `enc_sel`=0, condition code 0xF makes the word a non-match.
- R7: For `enc_sel`=1, a matching word always gives `wr_en`=1 unless R10 applies. The flags are ignored.
- R8: A non-matching valid word gives `match`=0 and `wr_en`=0, and `result` keeps its previous value.
- R9: For each valid input, `out_valid`, `match`, `wr_en`, `unpred`, the indices and `result` appear exactly one cycle later. `out_valid` is low one cycle after an idle input. Synchronous reset clears `out_valid`, `match`, `wr_en` and `unpred`.
- R10: For a matching word where Rn, Rd or Rm equals 15, `unpred` is 1 and `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| enc_sel | input | 1 | 0 = fixed-length layout, 1 = two-halfword layout |
| instr | input | 32 | Instruction word |
| flags | input | 4 | N, Z, C, V from bit 3 down to bit 0 |
| op_a | input | 32 | First source value (Rn) |
| op_b | input | 32 | Second source value (Rm) |
| out_valid | output | 1 | Registered outputs carry a result |
| match | output | 1 | Word was recognised |
| rn_idx | output | 4 | First source index |
| rd_idx | output | 4 | Destination index |
| rm_idx | output | 4 | Second source index |
| wr_en | output | 1 | Destination write enable |
| unpred | output | 1 | A register index of 15 was named |
| result | output | 32 | Packed saturated sum |

## Verification
Two functions can act on the same instruction:
- the condition gate, which clears the write when the condition fails;
- the register-15 check, which also clears the write and raises `unpred`.

The bench sends fixed-layout words that carry a failing condition together with a 15 in Rm. The scoreboard expects `match` high, `unpred` high and `wr_en` low, with the result still updated.

Within one word, the bench also mixes lanes that saturate with lanes that pass through. This confirms that a clamp in one lane neither leaks a carry into its neighbour nor disturbs it.

// File: rtl/pbsat_pkg.sv
package pbsat_pkg;

    localparam int INSTR_W = 32;
    localparam int IDX_W   = 4;
    localparam int FLAG_W  = 4;

    typedef struct packed {
        logic             match;
        logic             wr_en;
        logic             unpred;
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] rm;
    } dec_t;

    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } out_state_t;

endpackage

// File: rtl/pbsat_lanes.sv
module pbsat_lanes #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int LANES = DATA_W / LANE_W;
    localparam logic [LANE_W-1:0] LANE_MAX = '1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] la, lb, ly;
        logic [LANE_W:0]   wide;

        always_comb begin
            la   = a[g*LANE_W +: LANE_W];
            lb   = b[g*LANE_W +: LANE_W];
            wide = {1'b0, la} + {1'b0, lb};
            ly   = wide[LANE_W] ? LANE_MAX : wide[LANE_W-1:0];
        end

        assign y[g*LANE_W +: LANE_W] = ly;

        // an unsigned saturating sum never falls below either addend
        always_comb begin
            assert_lane_floor_R2: assert (ly >= la && ly >= lb)
                else $error("lane %0d below an addend", g);
        end
    end

endmodule

// File: rtl/pbsat_decode.sv
module pbsat_decode
    import pbsat_pkg::*;
(
    input  logic               enc_sel,
    input  logic [INSTR_W-1:0] instr,
    input  logic [FLAG_W-1:0]  flags,
    output dec_t               dec
);
    logic       fl_n, fl_z, fl_c, fl_v;
    logic [3:0] cond;
    logic       cond_ok;
    logic       hit_fixed, hit_split;
    logic       hit;
    logic [3:0] rn, rd, rm;

    assign fl_n = flags[3];
    assign fl_z = flags[2];
    assign fl_c = flags[1];
    assign fl_v = flags[0];
    assign cond = instr[31:28];

    always_comb begin
        unique case (cond)
            4'h0: cond_ok = fl_z;
            4'h1: cond_ok = !fl_z;
            4'h2: cond_ok = fl_c;
            4'h3: cond_ok = !fl_c;
            4'h4: cond_ok = fl_n;
            4'h5: cond_ok = !fl_n;
            4'h6: cond_ok = fl_v;
            4'h7: cond_ok = !fl_v;
            4'h8: cond_ok = fl_c && !fl_z;
            4'h9: cond_ok = !fl_c || fl_z;
            4'hA: cond_ok = (fl_n == fl_v);
            4'hB: cond_ok = (fl_n != fl_v);
            4'hC: cond_ok = !fl_z && (fl_n == fl_v);
            4'hD: cond_ok = fl_z || (fl_n != fl_v);
            4'hE: cond_ok = 1'b1;
            4'hF: cond_ok = 1'b0;
        endcase
    end

    assign hit_fixed = !enc_sel && (instr[27:20] == 8'h66) &&
                       (instr[11:8] == 4'hF) && (instr[7:4] == 4'h9) &&
                       (cond != 4'hF);
    assign hit_split = enc_sel && (instr[31:20] == 12'hFA8) &&
                       (instr[15:12] == 4'hF) && (instr[7:4] == 4'h5);
    assign hit = hit_fixed || hit_split;

    assign rn = instr[19:16];
    assign rm = instr[3:0];
    assign rd = enc_sel ? instr[11:8] : instr[15:12];

    always_comb begin
        dec.match  = hit;
        dec.rn     = rn;
        dec.rd     = rd;
        dec.rm     = rm;
        dec.unpred = hit && ((rn == 4'hF) || (rd == 4'hF) || (rm == 4'hF));
        dec.wr_en  = hit && !dec.unpred && (enc_sel || cond_ok);
    end

    always_comb begin
        if (!enc_sel && cond == 4'hF) begin
            assert_cond_never_R6: assert (!dec.match)
                else $error("condition 0xF decoded as a match");
        end
    end

endmodule

// File: rtl/pbsat_out_stage.sv
module pbsat_out_stage
    import pbsat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] lane_sum,
    output logic              out_valid,
    output logic              match,
    output logic              wr_en,
    output logic              unpred,
    output logic [IDX_W-1:0]  rn_idx,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  rm_idx,
    output logic [DATA_W-1:0] result
);
    out_state_t state, state_nx;

    always_comb begin
        unique case (state)
            OS_EMPTY: state_nx = in_valid ? OS_FULL : OS_EMPTY;
            OS_FULL:  state_nx = in_valid ? OS_FULL : OS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= OS_EMPTY;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match  <= 1'b0;
            wr_en  <= 1'b0;
            unpred <= 1'b0;
            rn_idx <= '0;
            rd_idx <= '0;
            rm_idx <= '0;
            result <= '0;
        end else if (in_valid) begin
            match  <= dec.match;
            wr_en  <= dec.wr_en;
            unpred <= dec.unpred;
            rn_idx <= dec.rn;
            rd_idx <= dec.rd;
            rm_idx <= dec.rm;
            if (dec.match) result <= lane_sum;
        end else begin
            match  <= 1'b0;
            wr_en  <= 1'b0;
            unpred <= 1'b0;
        end
    end

    assign out_valid = (state == OS_FULL);

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_result_held_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dec.match) |=> $stable(result));
    assert_no_write_unpred_R10: assert property (@(posedge clk) disable iff (rst)
        unpred |-> !wr_en);
    assert_write_needs_match_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (match && out_valid));

endmodule

// File: rtl/pbsat_add_unit.sv
module pbsat_add_unit #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              enc_sel,
    input  logic [31:0]       instr,
    input  logic [3:0]        flags,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              out_valid,
    output logic              match,
    output logic [3:0]        rn_idx,
    output logic [3:0]        rd_idx,
    output logic [3:0]        rm_idx,
    output logic              wr_en,
    output logic              unpred,
    output logic [DATA_W-1:0] result
);
    import pbsat_pkg::*;

    dec_t              dec;
    logic [DATA_W-1:0] lane_sum;

    pbsat_decode u_decode (
        .enc_sel (enc_sel),
        .instr   (instr),
        .flags   (flags),
        .dec     (dec)
    );

    pbsat_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lanes (
        .a (op_a),
        .b (op_b),
        .y (lane_sum)
    );

    pbsat_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .dec       (dec),
        .lane_sum  (lane_sum),
        .out_valid (out_valid),
        .match     (match),
        .wr_en     (wr_en),
        .unpred    (unpred),
        .rn_idx    (rn_idx),
        .rd_idx    (rd_idx),
        .rm_idx    (rm_idx),
        .result    (result)
    );

endmodule

// File: tb/pbsat_add_unit_tb.sv
module pbsat_add_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        enc_sel;
    logic [31:0] instr;
    logic [3:0]  flags;
    logic [31:0] op_a, op_b;
    logic        out_valid, match, wr_en, unpred;
    logic [3:0]  rn_idx, rd_idx, rm_idx;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;
    logic [31:0] last_res = 32'h0;
    bit done = 0;

    typedef struct {
        logic [31:0] res;
        logic        m, we, up;
        logic [3:0]  rn, rd, rm;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    pbsat_add_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .enc_sel(enc_sel),
        .instr(instr), .flags(flags), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .match(match), .rn_idx(rn_idx),
        .rd_idx(rd_idx), .rm_idx(rm_idx), .wr_en(wr_en),
        .unpred(unpred), .result(result)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit cond_pass(input logic [3:0] c, input logic [3:0] f);
        bit n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] sat_model(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            int s;
            s = int'(a[i*8 +: 8]) + int'(b[i*8 +: 8]);
            r[i*8 +: 8] = (s > 255) ? 8'hFF : s[7:0];
        end
        return r;
    endfunction

    function automatic logic [31:0] mk_fixed(input logic [3:0] c, input logic [3:0] n,
                                             input logic [3:0] d, input logic [3:0] m);
        return {c, 8'h66, n, d, 8'hF9, m};
    endfunction

    function automatic logic [31:0] mk_split(input logic [3:0] n, input logic [3:0] d,
                                             input logic [3:0] m);
        return {12'hFA8, n, 4'hF, d, 4'h5, m};
    endfunction

    task automatic drive(input logic es, input logic [31:0] w, input logic [3:0] f,
                         input logic [31:0] a, input logic [31:0] b, input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; enc_sel = es; instr = w; flags = f; op_a = a; op_b = b;
        e.rn = w[19:16];
        e.rm = w[3:0];
        if (!es) begin
            e.rd = w[15:12];
            e.m  = (w[27:20] == 8'h66) && (w[11:8] == 4'hF) &&
                   (w[7:4] == 4'h9) && (w[31:28] != 4'hF);
        end else begin
            e.rd = w[11:8];
            e.m  = (w[31:20] == 12'hFA8) && (w[15:12] == 4'hF) && (w[7:4] == 4'h5);
        end
        e.up = e.m && (e.rn == 4'hF || e.rd == 4'hF || e.rm == 4'hF);
        e.we = e.m && !e.up && (es || cond_pass(w[31:28], f));
        if (e.m) last_res = sat_model(a, b);
        e.res = last_res;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pops the oldest expectation whenever a result is presented
    always @(negedge clk) begin
        if (!rst && !done && out_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R9", "unexpected out_valid", 32'(out_valid), 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(match == e.m, e.req, "match", 32'(match), 32'(e.m));
                chk(wr_en == e.we, e.req, "wr_en", 32'(wr_en), 32'(e.we));
                chk(unpred == e.up, e.req, "unpred", 32'(unpred), 32'(e.up));
                chk(result == e.res, e.req, "result", result, e.res);
                chk({rn_idx, rd_idx, rm_idx} == {e.rn, e.rd, e.rm}, e.req, "indices",
                    32'({rn_idx, rd_idx, rm_idx}), 32'({e.rn, e.rd, e.rm}));
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(0, "R9", "watchdog expired", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; enc_sel = 1'b0; instr = '0; flags = '0;
        op_a = '0; op_b = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && match == 0 && wr_en == 0 && unpred == 0, "R9",
            "reset state", 32'({out_valid, match, wr_en, unpred}), 32'h0);
        rst = 1'b0;

        // R1 / R2: mixed saturating and passing lanes, exact 255 boundary
        drive(0, mk_fixed(4'hE, 1, 2, 3), 4'h0, 32'h01FF807F, 32'h01017F80, "R2");
        drive(0, mk_fixed(4'hE, 4, 5, 6), 4'h0, 32'h12345678, 32'h01010101, "R1");
        drive(0, mk_fixed(4'hE, 0, 1, 2), 4'h0, 32'h00FF00FF, 32'h00010001, "R1");
        drive(0, mk_fixed(4'hE, 7, 8, 9), 4'h0, 32'h80FE0000, 32'h80010000, "R2");
        drive(0, mk_fixed(4'hE, 1, 1, 1), 4'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2");
        idle(1);
        @(negedge clk);
        chk(out_valid == 0, "R9", "valid after idle", 32'(out_valid), 32'h0);

        // R5: condition table
        drive(0, mk_fixed(4'h0, 1, 2, 3), 4'b0100, 32'h10203040, 32'h01020304, "R5");
        drive(0, mk_fixed(4'h0, 1, 2, 3), 4'b0000, 32'h11111111, 32'h22222222, "R5");
        drive(0, mk_fixed(4'hA, 1, 2, 3), 4'b1000, 32'h01010101, 32'h01010101, "R5");
        drive(0, mk_fixed(4'hA, 1, 2, 3), 4'b1001, 32'h02020202, 32'h01010101, "R5");
        drive(0, mk_fixed(4'h8, 1, 2, 3), 4'b0010, 32'h03030303, 32'h01010101, "R5");
        drive(0, mk_fixed(4'h8, 1, 2, 3), 4'b0110, 32'h04040404, 32'h01010101, "R5");
        drive(0, mk_fixed(4'hD, 1, 2, 3), 4'b0001, 32'h05050505, 32'h01010101, "R5");
        drive(0, mk_fixed(4'hC, 1, 2, 3), 4'b0001, 32'h06060606, 32'h01010101, "R5");
        drive(0, mk_fixed(4'h3, 1, 2, 3), 4'b0000, 32'h07070707, 32'h01010101, "R5");

        // R6 / R8: condition 0xF and damaged fields leave the result held
        drive(0, mk_fixed(4'hF, 1, 2, 3), 4'hF, 32'hAAAAAAAA, 32'h11111111, "R6");
        drive(0, mk_fixed(4'hE, 1, 2, 3) ^ 32'h00000020, 4'h0, 32'h12121212, 32'h1, "R3");
        drive(0, mk_fixed(4'hE, 1, 2, 3) ^ 32'h00100000, 4'h0, 32'h13131313, 32'h1, "R8");
        drive(0, mk_fixed(4'hE, 1, 2, 3) ^ 32'h00000100, 4'h0, 32'h14141414, 32'h1, "R3");

        // R4 / R7: two-halfword layout, flags ignored
        drive(1, mk_split(2, 3, 4), 4'h0, 32'hF0F0F0F0, 32'h20100F01, "R7");
        drive(1, mk_split(5, 6, 7), 4'hF, 32'h01020304, 32'h05060708, "R4");
        drive(1, mk_split(5, 6, 7) ^ 32'h00004000, 4'h0, 32'h99999999, 32'h1, "R4");
        drive(1, mk_fixed(4'hE, 1, 2, 3), 4'h0, 32'h9A9A9A9A, 32'h1, "R4");
        drive(0, mk_split(1, 2, 3), 4'h0, 32'h9B9B9B9B, 32'h1, "R3");

        // R10: register 15, alone and together with a failing condition
        drive(0, mk_fixed(4'hE, 1, 15, 3), 4'h0, 32'h0A0B0C0D, 32'h01010101, "R10");
        drive(1, mk_split(15, 2, 3), 4'h0, 32'h10101010, 32'h10101010, "R10");
        drive(0, mk_fixed(4'h0, 1, 2, 15), 4'b0000, 32'h20202020, 32'hF0F0F0F0, "R10");
        drive(1, mk_split(1, 2, 15), 4'h0, 32'h30303030, 32'h01010101, "R10");
        idle(3);

        done = 1;
        chk(sb.size() == 0, "R9", "results missing", 32'(sb.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule